// File: doc/BRIEF.md
# PHY Address Discovery Sequencer

This block finds which management address an attached Ethernet PHY answers on. It issues reads of the PHY basic status register (MII register 1) through a simple request/acknowledge read port, which an MDIO frame engine outside the block serves. A start pulse begins discovery.

When a preset address is marked valid, that address is probed first. A preset that passes is reported without any scan. Otherwise, or when the preset fails, the block probes every address from 31 down to 0 and stops at the first one that answers like a real PHY. At the end it raises a one-cycle done pulse and holds a found flag and the 5-bit address until the next accepted start.

The block has four states. IDLE waits for start. PROBE holds the read request. JUDGE applies the verdict. FINISH drives the done pulse. It moves between them on these transitions:
- start-accept: IDLE to PROBE.
- reply-or-expire: PROBE to JUDGE.
- preset-fallback: JUDGE to PROBE at address 31.
- step-down: JUDGE to PROBE at the next lower address.
- hit or exhausted: JUDGE to FINISH.
- retire: FINISH to IDLE.

Top module: `phy_probe_seq`

## Requirements
- R1: While `rd_req_o` is high, `rd_reg_o` equals 1 and `rd_phy_o` holds the probed address. The request stays high and the address stays stable until `rd_ack_i` is seen or the probe times out.
- R2: A probe that returns 16'hFFFF is rejected, even though that value has every capability bit set.
- R3: A probe passes only when the returned data has bits 12, 11 and 3 all set (mask 16'h1808) and is not 16'hFFFF. Any missing bit rejects the address.
- R4: With `preset_valid_i` high at start and the preset address passing, exactly one probe is issued and that address is reported found.
- R5: Otherwise, probes go to 31, 30, … in strictly descending order and stop at the first address that passes. When the preset is used and fails, it is probed once before address 31.
- R6: When no address passes, discovery ends with `found_o`=0 and `addr_o`=0 after all 32 scan probes.
- R7: If no acknowledge arrives within TIMEOUT_CYC request cycles, the probe counts as failed and the request drops. An acknowledge in the last cycle of that window is still honoured.
- R8: A start pulse while `busy_o` is high is ignored: probe sequence and result are those of the run already under way.
- R9: `done_o` is high for exactly one cycle per run. `busy_o` is high from the cycle after an accepted start through the done cycle. `found_o`/`addr_o` hold their values from done until the next accepted start.
- R10: After reset, `busy_o`, `done_o`, `rd_req_o`, `found_o` and `addr_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only in IDLE |
| preset_valid_i | input | 1 | Probe preset address first |
| preset_addr_i | input | 5 | Preset PHY address |
| rd_req_o | output | 1 | Read request to management engine |
| rd_phy_o | output | 5 | PHY address of the read |
| rd_reg_o | output | 5 | Register number of the read (always 1) |
| rd_ack_i | input | 1 | Read completion strobe |
| rd_data_i | input | 16 | Read data, valid with `rd_ack_i` |
| busy_o | output | 1 | Discovery in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| found_o | output | 1 | A PHY was found |
| addr_o | output | 5 | Found address (0 when not found) |

## Verification
Two events can land in the same cycle: the engine's acknowledge and the expiry of the per-probe timeout. The bench's PHY model delays the acknowledge by a chosen number of request cycles. It places one acknowledge exactly in the last window cycle, where it must be accepted, and one a cycle later, where the probe must count as failed. Each case is judged by the reported address and the recorded probe sequence. Random runs also mix these latencies into the scan.

// File: rtl/phy_probe_pkg.sv
package phy_probe_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PROBE  = 2'd1,
        ST_JUDGE  = 2'd2,
        ST_FINISH = 2'd3
    } probe_state_e;

endpackage

// File: rtl/phy_status_judge.sv
module phy_status_judge #(
    parameter int              DATA_W   = 16,
    parameter logic [DATA_W-1:0] CAP_MASK = 16'h1808
) (
    input  logic [DATA_W-1:0] data_i,
    output logic              accept_o
);
    logic all_ones;
    logic caps_ok;

    always_comb begin
        all_ones = &data_i;
        caps_ok  = (data_i & CAP_MASK) == CAP_MASK;
        accept_o = caps_ok && !all_ones;
    end
endmodule

// File: rtl/probe_timer.sv
module probe_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);
    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (run_i)
            cnt_q <= cnt_q + 1'b1;
        else
            cnt_q <= '0;
    end

    assign expired_o = run_i && (cnt_q == CW'(LIMIT - 1));

    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        expired_o |=> (cnt_q == '0) || !run_i || (cnt_q == CW'(LIMIT)));
endmodule

// File: rtl/probe_addr_gen.sv
module probe_addr_gen #(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_preset_i,
    input  logic [ADDR_W-1:0] preset_i,
    input  logic              load_top_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              at_floor_o
);
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            addr_q <= '0;
        else if (load_preset_i)
            addr_q <= preset_i;
        else if (load_top_i)
            addr_q <= '1;
        else if (step_i)
            addr_q <= addr_q - 1'b1;
    end

    assign addr_o     = addr_q;
    assign at_floor_o = (addr_q == '0);

    assert_step_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_preset_i && !load_top_i) |=> (addr_q == $past(addr_q) - 1'b1));
endmodule

// File: rtl/phy_probe_seq.sv
module phy_probe_seq
    import phy_probe_pkg::*;
#(
    parameter int                ADDR_W      = 5,
    parameter int                REG_W       = 5,
    parameter int                DATA_W      = 16,
    parameter logic [REG_W-1:0]  STATUS_REG  = 5'd1,
    parameter logic [DATA_W-1:0] CAP_MASK    = 16'h1808,
    parameter int                TIMEOUT_CYC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              preset_valid_i,
    input  logic [ADDR_W-1:0] preset_addr_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_phy_o,
    output logic [REG_W-1:0]  rd_reg_o,
    input  logic              rd_ack_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              found_o,
    output logic [ADDR_W-1:0] addr_o
);
    probe_state_e state_q, state_d;

    logic              ld_preset, ld_top, step, capture;
    logic              tmr_expired;
    logic              data_accept;
    logic              ok_q;
    logic              scan_q;
    logic [DATA_W-1:0] data_q;
    logic [ADDR_W-1:0] cur_addr;
    logic              at_floor;
    logic              found_q;
    logic [ADDR_W-1:0] addr_q;

    phy_status_judge #(.DATA_W(DATA_W), .CAP_MASK(CAP_MASK)) u_judge (
        .data_i   (rd_data_i),
        .accept_o (data_accept)
    );

    probe_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (state_q == ST_PROBE),
        .expired_o (tmr_expired)
    );

    probe_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk           (clk),
        .rst_n         (rst_n),
        .load_preset_i (ld_preset),
        .preset_i      (preset_addr_i),
        .load_top_i    (ld_top),
        .step_i        (step),
        .addr_o        (cur_addr),
        .at_floor_o    (at_floor)
    );

    // next-state and control strobes
    always_comb begin
        state_d   = state_q;
        ld_preset = 1'b0;
        ld_top    = 1'b0;
        step      = 1'b0;
        capture   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    ld_preset = preset_valid_i;
                    ld_top    = !preset_valid_i;
                    state_d   = ST_PROBE;
                end
            end
            ST_PROBE: begin
                if (rd_ack_i || tmr_expired) begin
                    capture = 1'b1;
                    state_d = ST_JUDGE;
                end
            end
            ST_JUDGE: begin
                if (ok_q) begin
                    state_d = ST_FINISH;
                end else if (!scan_q) begin
                    ld_top  = 1'b1;
                    state_d = ST_PROBE;
                end else if (at_floor) begin
                    state_d = ST_FINISH;
                end else begin
                    step    = 1'b1;
                    state_d = ST_PROBE;
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // probe verdict and run bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ok_q    <= 1'b0;
            scan_q  <= 1'b0;
            data_q  <= '1;
            found_q <= 1'b0;
            addr_q  <= '0;
        end else begin
            if (capture) begin
                ok_q   <= rd_ack_i && data_accept;
                data_q <= rd_ack_i ? rd_data_i : '1;
            end
            if (state_q == ST_IDLE && start_i) begin
                scan_q  <= !preset_valid_i;
                found_q <= 1'b0;
                addr_q  <= '0;
            end else if (state_q == ST_JUDGE) begin
                if (ok_q) begin
                    found_q <= 1'b1;
                    addr_q  <= cur_addr;
                end else if (!scan_q) begin
                    scan_q <= 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        rd_req_o = (state_q == ST_PROBE);
        rd_phy_o = cur_addr;
        rd_reg_o = STATUS_REG;
        busy_o   = (state_q != ST_IDLE);
        done_o   = (state_q == ST_FINISH);
        found_o  = found_q;
        addr_o   = addr_q;
    end

    assert_req_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_ack_i && !tmr_expired) |=> (rd_req_o && $stable(rd_phy_o)));

    assert_reject_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_JUDGE) |-> !(ok_q && data_q == '1));

    assert_expire_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_expired |=> !rd_req_o);

    assert_stay_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(found_o) && $stable(addr_o)));

    assert_none_found_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !found_o) |-> (addr_o == '0));
endmodule

// File: tb/phy_probe_seq_bench.sv
module phy_probe_seq_bench;
    localparam int TMO = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        preset_valid_i = 1'b0;
    logic [4:0]  preset_addr_i = '0;
    logic        rd_req_o;
    logic [4:0]  rd_phy_o;
    logic [4:0]  rd_reg_o;
    logic        rd_ack_i = 1'b0;
    logic [15:0] rd_data_i = '0;
    logic        busy_o, done_o, found_o;
    logic [4:0]  addr_o;

    always #4 clk = ~clk;

    phy_probe_seq #(.TIMEOUT_CYC(TMO)) u_phy_probe_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .preset_valid_i(preset_valid_i), .preset_addr_i(preset_addr_i),
        .rd_req_o(rd_req_o), .rd_phy_o(rd_phy_o), .rd_reg_o(rd_reg_o),
        .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
        .busy_o(busy_o), .done_o(done_o), .found_o(found_o), .addr_o(addr_o)
    );

    int          n_checks = 0;
    int          n_fail   = 0;
    logic [15:0] mem [32];
    int          lat [32];
    int          seen [40];
    int          n_seen = 0;
    int          exp_seq [40];
    int          exp_n;
    bit          exp_found;
    int          exp_addr;
    int          req_cnt = 0;
    bit          req_prev = 1'b0;
    int          reg_bad = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit passes(input int a);
        return (lat[a] <= TMO - 1) && (mem[a] != 16'hFFFF) &&
               ((mem[a] & 16'h1808) == 16'h1808);
    endfunction

    task automatic compute_expect(input bit pv, input int pa);
        exp_n = 0; exp_found = 0; exp_addr = 0;
        if (pv) begin
            exp_seq[exp_n++] = pa;
            if (passes(pa)) begin exp_found = 1; exp_addr = pa; return; end
        end
        for (int a = 31; a >= 0; a--) begin
            exp_seq[exp_n++] = a;
            if (passes(a)) begin exp_found = 1; exp_addr = a; return; end
        end
    endtask

    // PHY model and probe monitor, all at negedge
    always @(negedge clk) begin
        if (!rst_n) begin
            rd_ack_i <= 1'b0; req_cnt = 0; req_prev = 1'b0;
        end else begin
            if (rd_req_o && !req_prev) begin
                if (n_seen < 40) seen[n_seen] = rd_phy_o;
                n_seen++;
            end
            if (rd_req_o && rd_reg_o != 5'd1) reg_bad++;
            req_prev = rd_req_o;
            if (rd_req_o) begin
                if (req_cnt == lat[rd_phy_o]) begin
                    rd_ack_i  <= 1'b1;
                    rd_data_i <= mem[rd_phy_o];
                end else begin
                    rd_ack_i  <= 1'b0;
                    rd_data_i <= $urandom;
                end
                req_cnt++;
            end else begin
                rd_ack_i <= 1'b0;
                req_cnt = 0;
            end
        end
    end

    task automatic fill_absent();
        for (int a = 0; a < 32; a++) begin mem[a] = 16'hFFFF; lat[a] = 1; end
    endtask

    task automatic run(input bit pv, input int pa, input int restart_at,
                       input string tag);
        int  guard;
        bit  busy_seen;
        bit  seq_ok;
        compute_expect(pv, pa);
        n_seen = 0; reg_bad = 0;
        @(negedge clk);
        preset_valid_i = pv; preset_addr_i = 5'(pa); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        busy_seen = busy_o;
        chk(busy_seen, "R9", {tag, " busy after start"}, busy_o, 1);
        guard = 0;
        while (!done_o && guard < 4000) begin
            if (restart_at > 0 && guard == restart_at) begin
                // R8: restart with a different setup while busy
                preset_valid_i = !pv; preset_addr_i = 5'(pa + 3); start_i = 1'b1;
            end else start_i = 1'b0;
            @(negedge clk);
            guard++;
        end
        start_i = 1'b0;
        chk(done_o, "R9", {tag, " done reached"}, done_o, 1);
        chk(found_o == exp_found, exp_found ? "R4/R5" : "R6",
            {tag, " found"}, found_o, exp_found);
        chk(addr_o == 5'(exp_addr), exp_found ? "R5" : "R6",
            {tag, " addr"}, addr_o, exp_addr);
        seq_ok = (n_seen == exp_n);
        for (int i = 0; i < exp_n && i < 40; i++)
            if (seen[i] != exp_seq[i]) seq_ok = 0;
        chk(seq_ok, restart_at > 0 ? "R8" : "R5", {tag, " probe sequence length"},
            n_seen, exp_n);
        chk(reg_bad == 0, "R1", {tag, " register number"}, reg_bad, 0);
        @(negedge clk);
        chk(!done_o && !busy_o, "R9", {tag, " done one cycle"}, done_o, 0);
        chk(found_o == exp_found && addr_o == 5'(exp_addr), "R9",
            {tag, " result held"}, addr_o, exp_addr);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++; n_checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        fill_absent();
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(!busy_o && !done_o && !rd_req_o && !found_o && addr_o == 0,
            "R10", "reset outputs", {busy_o, done_o, rd_req_o, found_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R4: preset passes, single probe
        fill_absent(); mem[7] = 16'h7849; mem[20] = 16'h1808;
        run(1, 7, 0, "R4 preset hit");

        // R2/R5: preset all-ones falls back to scan from 31
        fill_absent(); mem[20] = 16'h796D;
        run(1, 7, 0, "R2 preset ones");

        // R3: one missing capability bit rejects
        fill_absent(); mem[30] = 16'h1800; mem[29] = 16'h1008;
        mem[28] = 16'h0808; mem[3] = 16'h1808;
        run(0, 0, 0, "R3 mask bits");

        // R6: nothing answers
        fill_absent();
        run(0, 0, 0, "R6 empty bus");

        // R7: silent top, ack in last window cycle accepted
        fill_absent(); lat[31] = 1000; mem[31] = 16'h1808;
        mem[30] = 16'h1808; lat[30] = TMO - 1;
        run(0, 0, 0, "R7 ack at expiry");
        // R7: ack one cycle too late is a failure
        fill_absent(); mem[30] = 16'h1808; lat[30] = TMO; mem[12] = 16'h1809;
        run(0, 0, 0, "R7 late ack");

        // R8: start during busy ignored
        fill_absent(); mem[9] = 16'h1808; mem[25] = 16'h1808; lat[25] = 1000;
        run(0, 0, 5, "R8 restart ignored");

        // random mix
        for (int t = 0; t < 30; t++) begin
            for (int a = 0; a < 32; a++) begin
                int r = $urandom_range(0, 9);
                mem[a] = (r < 7) ? 16'hFFFF :
                         (r < 9) ? 16'($urandom) : (16'($urandom) | 16'h1808);
                r = $urandom_range(0, 9);
                lat[a] = (r == 0) ? TMO - 1 : (r == 1) ? TMO : $urandom_range(0, 3);
            end
            run($urandom_range(0, 1), $urandom_range(0, 31),
                (t % 5 == 0) ? 4 : 0, "random");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule